// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one synchronous DRAM burst. A memory controller pulses a start request together with a starting column, a burst length code and an ordering choice. From the next clock on, the block presents one column per clock with a valid flag. A last flag marks the final beat of a fixed-length burst.

Fixed bursts cover one, two, four or eight beats. The columns either count upward and wrap inside the naturally aligned block, or they take the start column XOR the beat number on the low bits. A page mode steps through the whole row and wraps modulo the row size. It runs until the controller asks it to stop or starts a new burst. A stop request may cut any burst short. A new start replaces a running burst with no idle cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and after reset until the first start, `colValid` and `colLast` are 0. A stop request with no burst running leaves `colValid` at 0.
- R2: A start sampled on a clock edge makes `colValid` 1 from that edge on, and the first beat's `colAddr` equals `startCol`.
- R3: `burstLen` codes: 3'b000 gives one beat, 3'b001 two, 3'b010 four, 3'b011 eight, 3'b111 page mode. The reserved codes 3'b100 to 3'b110 give one beat. Without stop or restart, a fixed burst holds `colValid` for exactly that many consecutive cycles and then drops it.
- R4: With `burstInterleave` at 0, beat k carries the start column's upper bits unchanged. Its low log2(BL) bits equal (start low bits + k) mod BL.
- R5: With `burstInterleave` at 1, beat k equals the start column with its low log2(BL) bits XORed with k.
- R6: `colLast` is 1 on the final beat of a fixed burst only, and never while `colValid` is 0.
- R7: In page mode, beat k is (startCol + k) mod 512. `burstInterleave` is ignored and `colLast` stays 0.
- R8: A stop request sampled while a beat is shown and no start is present makes that beat the final one. `colValid` is 0 after the edge.
- R9: A start sampled during a burst, even with a stop request present, shows the new burst's first beat on the next cycle.
- R10: Length and ordering are captured at start. Changing `burstLen` or `burstInterleave` during a burst has no effect on its columns, length or last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin a new burst on this edge |
| startCol | input | 9 | First column of the burst |
| burstLen | input | 3 | Burst length code (R3) |
| burstInterleave | input | 1 | 0 = wrapping increment, 1 = XOR ordering |
| stopReq | input | 1 | End the running burst after the current beat |
| colAddr | output | 9 | Column of the current beat |
| colValid | output | 1 | A beat is being presented |
| colLast | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Every fixed length runs under both orderings from every offset inside an eight-column block, on top of a non-zero upper field. This separates a wrap inside the aligned window from a carry into the upper bits, and increment order from XOR order. That carry is visible only when the offset is non-zero. A table of scattered start columns adds the reserved length code and mixed upper fields. Directed cases cover the following:
- a page burst that crosses column 511 with interleave requested
- a stop partway through a burst
- a restart that collides with a stop
- a stop with no burst running

In every burst the length and ordering inputs are flipped after the start, which shows that they are captured at start.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LEN_CODE_W = 3;

  localparam logic [LEN_CODE_W-1:0] LEN_1    = 3'b000;
  localparam logic [LEN_CODE_W-1:0] LEN_2    = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LEN_4    = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LEN_8    = 3'b011;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'b111;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new burst
    logic step;   // advance to the next beat
    logic page;   // captured burst runs across the whole row
  } colStrobes_t;
endpackage

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  stopReq,
  input  logic [LEN_CODE_W-1:0] burstLen,
  output colStrobes_t           strobes,
  output logic [COL_W-1:0]      newMask,
  output logic                  colValid,
  output logic                  colLast
);
  logic             active;
  logic             pageReg;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] maskReg;
  logic             isPage;

  // decode of the length code into a low-bit window mask
  always_comb begin
    isPage = 1'b0;
    unique case (burstLen)
      LEN_2:    newMask = COL_W'(1);
      LEN_4:    newMask = COL_W'(3);
      LEN_8:    newMask = COL_W'(7);
      LEN_PAGE: begin newMask = '1; isPage = 1'b1; end
      default:  newMask = '0;   // one beat, reserved codes included
    endcase
  end

  assign colValid = active;
  assign colLast  = active && !pageReg && (beatIdx == maskReg);

  always_comb begin
    strobes.load = startReq;
    strobes.page = isPage;
    strobes.step = !startReq && active && !stopReq && !colLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      pageReg <= 1'b0;
      beatIdx <= '0;
      maskReg <= '0;
    end else if (strobes.load) begin
      active  <= 1'b1;
      pageReg <= isPage;
      beatIdx <= '0;
      maskReg <= newMask;
    end else if (active) begin
      if (stopReq || colLast) active <= 1'b0;
      else                    beatIdx <= beatIdx + COL_W'(1);
    end
  end
endmodule

// File: rtl/burst_col_dp.sv
module burst_col_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobes_t      strobes,
  input  logic [COL_W-1:0] newMask,
  input  logic [COL_W-1:0] startCol,
  input  logic             burstInterleave,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] offset;
  logic [COL_W-1:0] maskReg;
  logic             xorOrder;
  logic [COL_W-1:0] lowSeq;
  logic [COL_W-1:0] lowXor;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol  <= '0;
      offset   <= '0;
      maskReg  <= '0;
      xorOrder <= 1'b0;
    end else if (strobes.load) begin
      baseCol  <= startCol;
      offset   <= '0;
      maskReg  <= newMask;
      xorOrder <= burstInterleave && !strobes.page;
    end else if (strobes.step) begin
      offset   <= offset + COL_W'(1);
    end
  end

  // page mode has an all-ones mask, so the sum wraps over the whole row
  always_comb begin
    lowSeq  = (baseCol + offset) & maskReg;
    lowXor  = (baseCol ^ offset) & maskReg;
    colAddr = (baseCol & ~maskReg) | (xorOrder ? lowXor : lowSeq);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic [COL_W-1:0]      startCol,
  input  logic [LEN_CODE_W-1:0] burstLen,
  input  logic                  burstInterleave,
  input  logic                  stopReq,
  output logic [COL_W-1:0]      colAddr,
  output logic                  colValid,
  output logic                  colLast
);
  colStrobes_t      strobes;
  logic [COL_W-1:0] newMask;

  burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stopReq  (stopReq),
    .burstLen (burstLen),
    .strobes  (strobes),
    .newMask  (newMask),
    .colValid (colValid),
    .colLast  (colLast)
  );

  burst_col_dp #(.COL_W(COL_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .newMask         (newMask),
    .startCol        (startCol),
    .burstInterleave (burstInterleave),
    .colAddr         (colAddr)
  );
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  startReq,
  input logic [COL_W-1:0]      startCol,
  input logic [LEN_CODE_W-1:0] burstLen,
  input logic                  stopReq,
  input logic [COL_W-1:0]      colAddr,
  input logic                  colValid,
  input logic                  colLast
);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    !colValid && !startReq |=> !colValid);

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> colValid && colAddr == $past(startCol));

  assert_ends_after_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    colLast && !startReq |=> !colValid);

  assert_runs_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    colValid && !colLast && !stopReq && !startReq |=> colValid);

  assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid);

  assert_page_first_not_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    startReq && burstLen == LEN_PAGE |=> !colLast);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rstN)
    colValid && stopReq && !startReq |=> !colValid);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {beats[3:0], interleave, len[2:0], startCol[8:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {4'd1, 1'b0, 3'b000, 9'h1FF},
    {4'd2, 1'b0, 3'b001, 9'h0B3},
    {4'd2, 1'b1, 3'b001, 9'h100},
    {4'd4, 1'b0, 3'b010, 9'h1FE},
    {4'd4, 1'b1, 3'b010, 9'h02D},
    {4'd8, 1'b0, 3'b011, 9'h1FD},
    {4'd8, 1'b1, 3'b011, 9'h0F6},
    {4'd1, 1'b1, 3'b101, 9'h077},
    {4'd1, 1'b0, 3'b100, 9'h155},
    {4'd1, 1'b1, 3'b110, 9'h0AA}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] burstLen = '0;
  logic       burstInterleave = 1'b0;
  logic       stopReq = 1'b0;
  logic [8:0] colAddr;
  logic       colValid;
  logic       colLast;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startCol(startCol),
    .burstLen(burstLen), .burstInterleave(burstInterleave), .stopReq(stopReq),
    .colAddr(colAddr), .colValid(colValid), .colLast(colLast)
  );

  function automatic int beatsOf(logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] modelCol(int start, logic [2:0] code, bit il, int k);
    int bl = beatsOf(code);
    int off, blk;
    if (bl == 512) return 9'((start + k) % 512);
    off = start % bl;
    blk = start - off;
    if (il) return 9'(blk + (off ^ k));
    return 9'(blk + ((off + k) % bl));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // pulse start; returns at the negedge where beat 0 is shown
  task automatic launch(logic [8:0] col, logic [2:0] code, bit il);
    @(negedge clk);
    startReq = 1'b1; startCol = col; burstLen = code; burstInterleave = il;
    @(negedge clk);
    startReq = 1'b0; startCol = ~col;
    burstLen = ~code; burstInterleave = ~il;   // R10: must not matter
  endtask

  // checks beats; leaves at the negedge after the last checked beat
  task automatic follow(logic [8:0] col, logic [2:0] code, bit il, int beats, bit page);
    for (int k = 0; k < beats; k++) begin
      chk("R2 valid", int'(colValid), 1);
      chk(il && !page ? "R5 column" : (page ? "R7 column" : "R4 column"),
          int'(colAddr), int'(modelCol(col, code, il, k)));
      chk(page ? "R7 last" : "R6 last", int'(colLast), int'(!page && k == beats - 1));
      @(negedge clk);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(colValid), 0);
    chk("R1 last in reset", int'(colLast), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(colValid), 0);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    @(negedge clk);
    chk("R1 stop while idle", int'(colValid), 0);

    // table walk (R3, R4, R5, R6, R10)
    for (int v = 0; v < NVEC; v++) begin
      launch(VEC[v][8:0], VEC[v][11:9], VEC[v][12]);
      follow(VEC[v][8:0], VEC[v][11:9], VEC[v][12], int'(VEC[v][16:13]), 1'b0);
      chk("R3 ends after length", int'(colValid), 0);
    end

    // every length, order and offset inside an 8-block (R3, R4, R5)
    for (int c = 0; c < 4; c++) begin
      for (int il = 0; il < 2; il++) begin
        for (int off = 0; off < 8; off++) begin
          logic [8:0] col = 9'(9'h1A8 + off);
          launch(col, 3'(c), il[0]);
          follow(col, 3'(c), il[0], beatsOf(3'(c)), 1'b0);
          chk("R3 ends after length", int'(colValid), 0);
        end
      end
    end

    // R7: page across column 511, interleave ignored, then R8 stop
    launch(9'h1FA, 3'b111, 1'b1);
    follow(9'h1FA, 3'b111, 1'b1, 11, 1'b1);
    chk("R7 page column", int'(colAddr), int'(modelCol(9'h1FA, 3'b111, 1'b0, 11)));
    chk("R7 page still valid", int'(colValid), 1);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8 page stopped", int'(colValid), 0);

    // R8: stop on beat 2 of an eight-beat burst
    launch(9'h035, 3'b011, 1'b0);
    follow(9'h035, 3'b011, 1'b0, 2, 1'b1);
    chk("R8 beat before stop", int'(colAddr), int'(modelCol(9'h035, 3'b011, 1'b0, 2)));
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    chk("R8 stopped", int'(colValid), 0);
    chk("R8 no last after stop", int'(colLast), 0);

    // R9: restart on beat 3 with a stop present
    launch(9'h0E1, 3'b011, 1'b1);
    follow(9'h0E1, 3'b011, 1'b1, 3, 1'b1);
    startReq = 1'b1; stopReq = 1'b1;
    startCol = 9'h0C3; burstLen = 3'b010; burstInterleave = 1'b1;
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0; burstLen = 3'b000; burstInterleave = 1'b0;
    chk("R9 restart valid", int'(colValid), 1);
    follow(9'h0C3, 3'b010, 1'b1, 4, 1'b0);
    chk("R9 restarted burst ends", int'(colValid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule